// File: doc/BRIEF.md
# Branch and Jump Next-PC Resolver

This combinational block resolves control transfer for a scalar integer pipeline. Each cycle it receives the current program counter, the sequential successor already computed upstream, two register operands, a sign-extended offset and the opcode and funct3 fields of the instruction. From these it produces the next program counter, a taken flag, a link-write enable with its link value, and an illegal flag for malformed control encodings.

Conditional branches test one of six conditions: equality and inequality, and less-than and greater-or-equal in both signed and unsigned forms. A direct jump adds the offset to the current PC. A register-indirect jump adds the offset to the first operand and forces bit 0 of the sum to zero. Both jump forms write the link value. Opcodes that are not control transfers fall through to the sequential PC with every flag low. Immediate extraction and alignment faults are handled elsewhere.

Two parameters pick the hardware variants. One chooses between a single shared subtractor and separate native comparators for the ordering tests. The other chooses between one shared target adder with a muxed base and two dedicated adders. The behaviour at the ports is the same for all four combinations.

Top module: `bj_next_pc`

## Requirements
- R1: With opcode 0x63, funct3 0 takes the branch when the operands are equal and funct3 1 takes it when they differ.
- R2: With opcode 0x63, funct3 4 takes the branch when operand A is less than operand B as two's-complement numbers, and funct3 5 takes it when A is greater than or equal to B.
- R3: With opcode 0x63, funct3 6 takes the branch when A is less than B as unsigned numbers, and funct3 7 takes it when A is greater than or equal to B.
- R4: A taken branch drives next_pc to cur_pc + offset. A branch that is not taken drives next_pc to seq_pc. A branch never raises link_we.
- R5: Opcode 0x6F raises taken and link_we, drives next_pc to cur_pc + offset and drives link_val to seq_pc.
- R6: Opcode 0x67 with funct3 0 raises taken and link_we, drives next_pc to (opnd_a + offset) with bit 0 forced to zero, and drives link_val to seq_pc.
- R7: link_val depends only on seq_pc. A jump whose destination register is also its source register still links the old sequential PC, even when opnd_a holds that same value or any other value.
- R8: Opcode 0x63 with funct3 2 or 3 raises illegal, keeps taken and link_we low and drives next_pc to seq_pc.
- R9: Opcode 0x67 with any funct3 other than 0 raises illegal, keeps taken and link_we low and drives next_pc to seq_pc.
- R10: Every other opcode drives next_pc to seq_pc with taken, link_we and illegal low.
- R11: All target sums wrap modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | XLEN | Address of the current instruction |
| seq_pc | input | XLEN | Sequential successor address |
| opnd_a | input | XLEN | First register operand, also the indirect jump base |
| opnd_b | input | XLEN | Second register operand |
| offset | input | XLEN | Sign-extended offset immediate |
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | Minor function field |
| next_pc | output | XLEN | Resolved next program counter |
| taken | output | 1 | Control transfer is taken |
| link_we | output | 1 | Link register write enable |
| link_val | output | XLEN | Value to write to the link register |
| illegal | output | 1 | Malformed control encoding |

## Verification
Every funct3 value under the branch opcode is crossed with all ordered pairs drawn from a set of boundary operands: zero, one, two, all ones, minus two, the largest positive value, the most negative value and that value plus one. The pairs in which the sign bit differs separate the signed tests from the unsigned ones, and the pairs of equal operands separate strict from non-strict ordering. Jump vectors use odd and even base sums so that the bit-0 clearing is visible, and use offsets that wrap around the top of the address space. Both variant combinations of the block receive every vector, so a fault in either one shows at the ports.

// File: rtl/bj_pkg.sv
package bj_pkg;

   localparam int unsigned OPC_W = 7;
   localparam int unsigned F3_W  = 3;

   localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
   localparam logic [OPC_W-1:0] OPC_JDIR   = 7'h6F;
   localparam logic [OPC_W-1:0] OPC_JREG   = 7'h67;

   typedef enum logic [2:0] {
      CC_NEVER = 3'd0,
      CC_EQ    = 3'd1,
      CC_NE    = 3'd2,
      CC_LTS   = 3'd3,
      CC_GES   = 3'd4,
      CC_LTU   = 3'd5,
      CC_GEU   = 3'd6,
      CC_ALWAYS = 3'd7
   } cond_e;

   typedef struct packed {
      logic  is_branch;
      logic  is_jdir;
      logic  is_jreg;
      logic  bad;
      cond_e cond;
   } ctl_t;

endpackage

// File: rtl/bj_decode.sv
module bj_decode
   import bj_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [F3_W-1:0]  funct3,
   output ctl_t             ctl
);

   always_comb begin
      ctl = '{is_branch: 1'b0, is_jdir: 1'b0, is_jreg: 1'b0,
              bad: 1'b0, cond: CC_NEVER};
      unique case (opcode)
         OPC_BRANCH: begin
            case (funct3)
               3'd0: begin ctl.is_branch = 1'b1; ctl.cond = CC_EQ;  end
               3'd1: begin ctl.is_branch = 1'b1; ctl.cond = CC_NE;  end
               3'd4: begin ctl.is_branch = 1'b1; ctl.cond = CC_LTS; end
               3'd5: begin ctl.is_branch = 1'b1; ctl.cond = CC_GES; end
               3'd6: begin ctl.is_branch = 1'b1; ctl.cond = CC_LTU; end
               3'd7: begin ctl.is_branch = 1'b1; ctl.cond = CC_GEU; end
               default: ctl.bad = 1'b1;
            endcase
         end
         OPC_JDIR: begin
            ctl.is_jdir = 1'b1;
            ctl.cond    = CC_ALWAYS;
         end
         OPC_JREG: begin
            if (funct3 == '0) begin
               ctl.is_jreg = 1'b1;
               ctl.cond    = CC_ALWAYS;
            end else begin
               ctl.bad = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      if (opcode != OPC_BRANCH && opcode != OPC_JREG)
         a_r10_bad_only_ctl: assert (!ctl.bad);
      if (ctl.is_jdir || ctl.is_jreg)
         a_r5_jump_always: assert (ctl.cond == CC_ALWAYS);
   end

endmodule

// File: rtl/bj_compare.sv
module bj_compare
   import bj_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter bit          SHARED_SUB = 1'b1
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  cond_e           cond,
   output logic            hit
);

   localparam int unsigned MSB = XLEN - 1;

   logic eq, lt_s, lt_u;

   assign eq = (a == b);

   generate
      if (SHARED_SUB) begin : g_sub
         logic [XLEN:0] diff;
         assign diff = {1'b0, a} - {1'b0, b};
         assign lt_u = diff[XLEN];
         assign lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[MSB];
      end else begin : g_native
         assign lt_u = (a < b);
         assign lt_s = ($signed(a) < $signed(b));
      end
   endgenerate

   always_comb begin
      unique case (cond)
         CC_EQ:     hit = eq;
         CC_NE:     hit = !eq;
         CC_LTS:    hit = lt_s;
         CC_GES:    hit = !lt_s;
         CC_LTU:    hit = lt_u;
         CC_GEU:    hit = !lt_u;
         CC_ALWAYS: hit = 1'b1;
         default:   hit = 1'b0;
      endcase
   end

   always_comb begin
      if (eq) a_r2_eq_not_less: assert (!lt_s && !lt_u);
      if (a[MSB] == b[MSB]) a_r3_same_sign_agree: assert (lt_s == lt_u);
   end

endmodule

// File: rtl/bj_target.sv
module bj_target #(
   parameter int unsigned XLEN         = 64,
   parameter bit          SHARED_ADDER = 1'b1
)(
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] base_reg,
   input  logic [XLEN-1:0] offset,
   input  logic            use_reg,
   output logic [XLEN-1:0] target
);

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] lsb_clear;

   generate
      if (SHARED_ADDER) begin : g_one_adder
         logic [XLEN-1:0] base;
         assign base = use_reg ? base_reg : cur_pc;
         assign sum  = base + offset;
      end else begin : g_two_adders
         logic [XLEN-1:0] sum_pc, sum_reg;
         assign sum_pc  = cur_pc + offset;
         assign sum_reg = base_reg + offset;
         assign sum     = use_reg ? sum_reg : sum_pc;
      end
   endgenerate

   assign lsb_clear = {{(XLEN-1){1'b1}}, ~use_reg};
   assign target    = sum & lsb_clear;

endmodule

// File: rtl/bj_next_pc.sv
module bj_next_pc
   import bj_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter bit          SHARED_SUB   = 1'b1,
   parameter bit          SHARED_ADDER = 1'b1
)(
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   input  logic [XLEN-1:0]  offset,
   input  logic [OPC_W-1:0] opcode,
   input  logic [F3_W-1:0]  funct3,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             link_we,
   output logic [XLEN-1:0]  link_val,
   output logic             illegal
);

   generate
      if (XLEN < 8 || XLEN > 128) begin : g_bad_xlen
         $error("bj_next_pc: XLEN must lie in 8..128");
      end
   endgenerate

   ctl_t            ctl;
   logic            hit;
   logic [XLEN-1:0] target;

   bj_decode u_dec (
      .opcode (opcode),
      .funct3 (funct3),
      .ctl    (ctl)
   );

   bj_compare #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
      .a    (opnd_a),
      .b    (opnd_b),
      .cond (ctl.cond),
      .hit  (hit)
   );

   bj_target #(.XLEN(XLEN), .SHARED_ADDER(SHARED_ADDER)) u_tgt (
      .cur_pc   (cur_pc),
      .base_reg (opnd_a),
      .offset   (offset),
      .use_reg  (ctl.is_jreg),
      .target   (target)
   );

   // link value comes straight from the sequential PC input, never from the
   // resolved target, so a jump whose rd equals rs1 links the old successor
   assign taken    = hit;
   assign next_pc  = hit ? target : seq_pc;
   assign link_we  = ctl.is_jdir | ctl.is_jreg;
   assign link_val = seq_pc;
   assign illegal  = ctl.bad;

   always_comb begin
      if (illegal) begin
         a_r8_illegal_sequential: assert (next_pc == seq_pc && !taken && !link_we);
      end
      if (!taken) begin
         a_r4_not_taken_seq: assert (next_pc == seq_pc);
      end
      if (link_we) begin
         a_r7_link_old_pc: assert (taken && link_val == seq_pc);
      end
      if (opcode == OPC_JREG && taken) begin
         a_r6_reg_target_even: assert (next_pc[0] == 1'b0);
      end
   end

endmodule

// File: tb/tb_bj_next_pc.sv
module tb_bj_next_pc;

   localparam int unsigned XLEN = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [XLEN-1:0] cur_pc, seq_pc, opnd_a, opnd_b, offset;
   logic [6:0]      opcode;
   logic [2:0]      funct3;

   logic [XLEN-1:0] np0, lv0, np1, lv1;
   logic            tk0, lw0, il0, tk1, lw1, il1;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bj_next_pc #(.XLEN(XLEN), .SHARED_SUB(1'b1), .SHARED_ADDER(1'b1)) dut (
      .cur_pc(cur_pc), .seq_pc(seq_pc), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .offset(offset), .opcode(opcode), .funct3(funct3),
      .next_pc(np0), .taken(tk0), .link_we(lw0), .link_val(lv0), .illegal(il0)
   );

   bj_next_pc #(.XLEN(XLEN), .SHARED_SUB(1'b0), .SHARED_ADDER(1'b0)) dut_alt (
      .cur_pc(cur_pc), .seq_pc(seq_pc), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .offset(offset), .opcode(opcode), .funct3(funct3),
      .next_pc(np1), .taken(tk1), .link_we(lw1), .link_val(lv1), .illegal(il1)
   );

   function automatic logic [XLEN-1:0] opval(int k);
      case (k)
         0: return 64'd0;
         1: return 64'd1;
         2: return 64'd2;
         3: return '1;
         4: return -64'sd2;
         5: return 64'h7FFF_FFFF_FFFF_FFFF;
         6: return 64'h8000_0000_0000_0000;
         default: return 64'h8000_0000_0000_0001;
      endcase
   endfunction

   task automatic cmp_one(string req, string what, logic [XLEN-1:0] got,
                          logic [XLEN-1:0] exp);
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h (op %h f3 %0d a %h b %h)",
                  req, what, got, exp, opcode, funct3, opnd_a, opnd_b);
      end
   endtask

   task automatic apply(logic [6:0] op, logic [2:0] f3, logic [XLEN-1:0] pc,
                        logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                        logic [XLEN-1:0] off, string req);
      logic [XLEN-1:0] e_np, sq;
      logic e_tk, e_lw, e_il;
      @(negedge clk);
      sq = pc + 64'd4;
      cur_pc = pc; seq_pc = sq; opnd_a = a; opnd_b = b; offset = off;
      opcode = op; funct3 = f3;
      e_tk = 1'b0; e_lw = 1'b0; e_il = 1'b0;
      if (op == 7'h63) begin
         case (f3)
            3'd0: e_tk = (a == b);
            3'd1: e_tk = (a != b);
            3'd4: e_tk = ($signed(a) <  $signed(b));
            3'd5: e_tk = ($signed(a) >= $signed(b));
            3'd6: e_tk = (a <  b);
            3'd7: e_tk = (a >= b);
            default: e_il = 1'b1;
         endcase
         e_np = e_tk ? pc + off : sq;
      end else if (op == 7'h6F) begin
         e_tk = 1'b1; e_lw = 1'b1; e_np = pc + off;
      end else if (op == 7'h67 && f3 == 3'd0) begin
         e_tk = 1'b1; e_lw = 1'b1; e_np = (a + off) & ~64'd1;
      end else begin
         e_il = (op == 7'h67);
         e_np = sq;
      end
      #1;
      n_vec++;
      cmp_one(req, "next_pc",  np0, e_np);
      cmp_one(req, "taken",    {63'd0, tk0}, {63'd0, e_tk});
      cmp_one(req, "link_we",  {63'd0, lw0}, {63'd0, e_lw});
      cmp_one(req, "illegal",  {63'd0, il0}, {63'd0, e_il});
      if (e_lw) cmp_one(req, "link_val", lv0, sq);
      cmp_one(req, "alt next_pc", np1, e_np);
      cmp_one(req, "alt flags", {61'd0, tk1, lw1, il1}, {61'd0, e_tk, e_lw, e_il});
      if (e_lw) cmp_one(req, "alt link_val", lv1, sq);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      cur_pc = '0; seq_pc = 64'd4; opnd_a = '0; opnd_b = '0; offset = '0;
      opcode = 7'h13; funct3 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle state with a non-control opcode: R10
      apply(7'h13, 3'd0, 64'h1000, 64'd5, 64'd5, 64'h40, "R10");
      apply(7'h33, 3'd0, 64'h2000, '1, 64'd0, 64'h8, "R10");
      apply(7'h00, 3'd7, 64'h3000, 64'd3, 64'd3, 64'h10, "R10");

      // branch sweep: R1 R2 R3 R4 R8
      for (int f = 0; f < 8; f++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               string rq;
               case (f)
                  0, 1:    rq = "R1";
                  4, 5:    rq = "R2";
                  6, 7:    rq = "R3";
                  default: rq = "R8";
               endcase
               apply(7'h63, 3'(f), 64'h8000 + 64'(i * 16 + j * 128),
                     opval(i), opval(j),
                     (j[0]) ? -64'sd64 : 64'h100, rq);
            end
         end
      end

      // branch target and wrap: R4 R11
      apply(7'h63, 3'd0, 64'h4000, 64'd9, 64'd9, -64'sd8, "R4");
      apply(7'h63, 3'd1, 64'h4000, 64'd9, 64'd9, -64'sd8, "R4");
      apply(7'h63, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 64'd1, 64'h20, "R11");

      // direct jump: R5 R11
      apply(7'h6F, 3'd0, 64'h1_0000, 64'd0, 64'd0, 64'h7FC, "R5");
      apply(7'h6F, 3'd5, 64'h1_0000, '1, '1, -64'sd4096, "R5");
      apply(7'h6F, 3'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 64'd0, 64'h10, "R11");

      // indirect jump with odd and even sums: R6 R11
      apply(7'h67, 3'd0, 64'h2_0000, 64'h3_0001, 64'd0, 64'h10, "R6");
      apply(7'h67, 3'd0, 64'h2_0000, 64'h3_0000, 64'd0, 64'h11, "R6");
      apply(7'h67, 3'd0, 64'h2_0000, 64'h3_0000, 64'd0, 64'h20, "R6");
      apply(7'h67, 3'd0, 64'h2_0000, '1, 64'd0, 64'd4, "R11");

      // rd equal to rs1: opnd_a holds the sequential pc itself: R7
      apply(7'h67, 3'd0, 64'h5000, 64'h5004, 64'd0, 64'h101, "R7");
      apply(7'h67, 3'd0, 64'h6000, 64'h9999, 64'd0, -64'sd1, "R7");

      // malformed indirect jump: R9
      for (int f = 1; f < 8; f++)
         apply(7'h67, 3'(f), 64'h7000, 64'h7777, 64'd0, 64'h40, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule